// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-timer event unit. A shared 64-bit main counter runs outside the block and comes in as an input; the channel compares it against its own programmable comparator and raises a one-clock `fire` strobe toward the interrupt logic whenever its target is reached. Software programs the channel through a 32-bit register port that reaches six half-word locations: the low and high halves of the configuration word, the comparator and a 64-bit route word.

The channel runs as a one-shot timer or as a periodic timer. In periodic mode a hidden period register, loaded through a self-clearing "load period" flag, is added to the comparator at every match, so events keep coming at a fixed spacing. A narrow mode limits the comparator and period to 32 bits, compares only the low 32 counter bits, and makes the periodic addition wrap at 32 bits. In narrow one-shot use, a target that lies behind the counter's low half gives an extra event when the low half wraps past 2^32.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration low half reads 0x0000_000C (bit 2 = periodic capable, bit 3 = 64-bit capable), the configuration high half reads the ROUTE_CAP bitmap (default 0x0000_0004, bit 2 set), both comparator halves read 0xFFFF_FFFF and both route halves read 0.
- R2: In the configuration low half only bit 0 (arm), bit 1 (periodic), bit 4 (narrow) and bit 5 (load period) are writable; the capability bits keep their value and writes to the configuration high half have no effect.
- R3: A configuration write with bit 4 set clears the upper 32 bits of the comparator and of the period; while narrow, writes to the comparator high half are ignored.
- R4: A comparator half write in one-shot mode updates the comparator; in periodic mode it updates the period half, and the comparator half too only when the load-period flag is set; the load-period flag reads 0 after any comparator half write.
- R5: In periodic mode with a nonzero period each match adds the period to the comparator, the sum taken modulo 2^32 in narrow mode.
- R6: When a narrow one-shot channel is armed, or its comparator low half written while armed, with the comparator below the counter's low 32 bits, the next wrap of the low half (bit 31 falling) gives one extra fire; the wrap indication is re-evaluated at every such arming.
- R7: The channel is armed while bit 0 is 1; clearing bit 0 stops all fire strobes and drops a pending wrap event.
- R8: Each half of the comparator and of the route word is written separately, and writing one half keeps the other.
- R9: A match is the counter equal to the comparator over 64 bits, or over the low 32 bits in narrow mode; fire is high for one clock in the cycle after the matching counter value is sampled, and once per match even if the counter holds that value.
- R10: Register addresses are 0 config low, 1 config high, 2 comparator low, 3 comparator high, 4 route low, 5 route high; addresses 6 and 7 read 0 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_cnt | input | 64 | Shared main counter value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register half-word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| fire | output | 1 | One-clock event strobe |

## Verification
The bench builds the channel with its default parameters, a 32-bit half width and a route capability bitmap with bit 2 set. Because the bench drives the main counter itself and can load any value, it places the counter just below 2^32 and other half boundaries, which puts the narrow periodic wrap-around, the one-shot wrap event and the 64-bit versus 32-bit comparison within a few dozen cycles.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
    localparam int HW     = 32;
    localparam int CW     = 2 * HW;
    localparam int ADDR_W = 3;

    localparam int B_ARM    = 0;
    localparam int B_PERIOD = 1;
    localparam int B_PCAP   = 2;
    localparam int B_WCAP   = 3;
    localparam int B_NARROW = 4;
    localparam int B_LDPER  = 5;

    localparam logic [HW-1:0] CFG_WMASK = HW'((1 << B_ARM) | (1 << B_PERIOD) |
                                              (1 << B_NARROW) | (1 << B_LDPER));
    localparam logic [HW-1:0] CFG_RST   = HW'((1 << B_PCAP) | (1 << B_WCAP));

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG_LO = 3'd0,
        SEL_CFG_HI = 3'd1,
        SEL_CMP_LO = 3'd2,
        SEL_CMP_HI = 3'd3,
        SEL_RT_LO  = 3'd4,
        SEL_RT_HI  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [HW-1:0] cfg;
        logic [CW-1:0] cmp;
        logic [CW-1:0] per;
        logic [CW-1:0] route;
        logic          hit;
        logic          wrap_pend;
        logic          fire;
    } chan_state_t;
endpackage

// File: rtl/evt_match.sv
module evt_match #(
    parameter int HALF_W = 32
) (
    input  logic [2*HALF_W-1:0] cnt_i,
    input  logic [2*HALF_W-1:0] cmp_i,
    input  logic                narrow_i,
    output logic                match_o
);
    localparam int FULL_W = 2 * HALF_W;

    logic lo_eq;
    logic hi_eq;

    always_comb begin
        lo_eq   = (cnt_i[HALF_W-1:0] == cmp_i[HALF_W-1:0]);
        hi_eq   = (cnt_i[FULL_W-1:HALF_W] == cmp_i[FULL_W-1:HALF_W]);
        match_o = lo_eq && (narrow_i || hi_eq);
    end
endmodule

// File: rtl/evt_wrap_detect.sv
module evt_wrap_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic msb_i,
    output logic wrapped_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d    = msb_i;
        wrapped_o = prev_q && !msb_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R6
    wrap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped_o |-> ($past(msb_i) && !msb_i));
endmodule

// File: rtl/evt_rd_mux.sv
module evt_rd_mux
    import evt_chan_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic [ADDR_W-1:0]   sel_i,
    input  logic [HALF_W-1:0]   cfg_i,
    input  logic [HALF_W-1:0]   cap_hi_i,
    input  logic [2*HALF_W-1:0] cmp_i,
    input  logic [2*HALF_W-1:0] route_i,
    output logic [HALF_W-1:0]   rdata_o
);
    localparam int FULL_W = 2 * HALF_W;

    always_comb begin
        case (sel_i)
            SEL_CFG_LO: rdata_o = cfg_i;
            SEL_CFG_HI: rdata_o = cap_hi_i;
            SEL_CMP_LO: rdata_o = cmp_i[HALF_W-1:0];
            SEL_CMP_HI: rdata_o = cmp_i[FULL_W-1:HALF_W];
            SEL_RT_LO:  rdata_o = route_i[HALF_W-1:0];
            SEL_RT_HI:  rdata_o = route_i[FULL_W-1:HALF_W];
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_chan_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       main_cnt,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fire
);
    chan_state_t d, q;

    logic          match;
    logic          wrapped;
    logic          arm_q, per_mode, narrow;
    logic          ev_match, ev_wrap, reload;
    logic [CW-1:0] sum;
    logic [HW-1:0] cfg_new;

    assign arm_q    = q.cfg[B_ARM];
    assign per_mode = q.cfg[B_PERIOD];
    assign narrow   = q.cfg[B_NARROW];

    evt_match #(.HALF_W(HW)) u_match (
        .cnt_i    (main_cnt),
        .cmp_i    (q.cmp),
        .narrow_i (narrow),
        .match_o  (match)
    );

    evt_wrap_detect u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .msb_i     (main_cnt[HW-1]),
        .wrapped_o (wrapped)
    );

    evt_rd_mux #(.HALF_W(HW)) u_rd (
        .sel_i    (reg_addr),
        .cfg_i    (q.cfg),
        .cap_hi_i (ROUTE_CAP),
        .cmp_i    (q.cmp),
        .route_i  (q.route),
        .rdata_o  (reg_rdata)
    );

    always_comb begin
        d       = q;
        cfg_new = q.cfg;

        ev_match = arm_q && match && !q.hit;
        ev_wrap  = arm_q && narrow && !per_mode && q.wrap_pend && wrapped;
        reload   = ev_match && per_mode && (q.per != '0);
        sum      = q.cmp + q.per;

        d.fire = ev_match || ev_wrap;
        if (ev_wrap) d.wrap_pend = 1'b0;
        if (reload) begin
            d.cmp = narrow ? {{HW{1'b0}}, sum[HW-1:0]} : sum;
        end
        d.hit = arm_q && match && !reload;

        if (reg_wr) begin
            case (reg_addr)
                SEL_CFG_LO: begin
                    cfg_new = (q.cfg & ~CFG_WMASK) | (reg_wdata & CFG_WMASK);
                    d.cfg   = cfg_new;
                    if (reg_wdata[B_NARROW]) begin
                        d.cmp[CW-1:HW] = '0;
                        d.per[CW-1:HW] = '0;
                    end
                    if (!cfg_new[B_ARM]) begin
                        d.wrap_pend = 1'b0;
                        d.hit       = 1'b0;
                    end else if (!arm_q) begin
                        d.wrap_pend = cfg_new[B_NARROW] && !cfg_new[B_PERIOD] &&
                                      (d.cmp[HW-1:0] < main_cnt[HW-1:0]);
                    end
                end
                SEL_CMP_LO: begin
                    if (per_mode) d.per[HW-1:0] = reg_wdata;
                    if (!per_mode || q.cfg[B_LDPER]) d.cmp[HW-1:0] = reg_wdata;
                    d.cfg[B_LDPER] = 1'b0;
                    d.hit          = 1'b0;
                    if (arm_q && narrow && !per_mode) begin
                        d.wrap_pend = (reg_wdata < main_cnt[HW-1:0]);
                    end
                end
                SEL_CMP_HI: begin
                    if (!narrow) begin
                        if (per_mode) d.per[CW-1:HW] = reg_wdata;
                        if (!per_mode || q.cfg[B_LDPER]) d.cmp[CW-1:HW] = reg_wdata;
                    end
                    d.cfg[B_LDPER] = 1'b0;
                    d.hit          = 1'b0;
                end
                SEL_RT_LO: d.route[HW-1:0]  = reg_wdata;
                SEL_RT_HI: d.route[CW-1:HW] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg       <= CFG_RST;
            q.cmp       <= '1;
            q.per       <= '0;
            q.route     <= '0;
            q.hit       <= 1'b0;
            q.wrap_pend <= 1'b0;
            q.fire      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fire = q.fire;

    // R2
    cap_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cfg[B_PCAP] && q.cfg[B_WCAP]);

    // R3
    narrow_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (q.cmp[CW-1:HW] == '0) && (q.per[CW-1:HW] == '0));

    // R4
    ldper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == SEL_CMP_LO || reg_addr == SEL_CMP_HI)) |=> !q.cfg[B_LDPER]);

    // R7
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |=> !fire);

    // R5
    reload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(per_mode && arm_q && !reg_wr && (q.per != '0) && !narrow))
        |-> (q.cmp == $past(q.cmp + q.per)));
endmodule

// File: tb/sim_evt_cmp_channel.sv
`timescale 1ns/1ps
module sim_evt_cmp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] main_cnt = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fire;

    logic        cnt_run = 1'b0;
    logic        cnt_ld = 1'b0;
    logic [63:0] cnt_ld_val = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    evt_cmp_channel u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_cnt  (main_cnt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fire      (fire)
    );

    always @(negedge clk) begin
        if (cnt_ld)       main_cnt <= cnt_ld_val;
        else if (cnt_run) main_cnt <= main_cnt + 64'd1;
    end

    // monitor: pops expected fire points as the design produces them
    always @(posedge clk) begin
        #1;
        if (rst_n && fire && !finished) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected fire at cnt=%h expected none", main_cnt);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (main_cnt !== e) begin
                    errors++;
                    $display("FAIL %s fire at cnt=%h expected %h", t, main_cnt, e);
                end
            end
        end
    end

    task automatic expect_fire(input logic [63:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #2;
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s read addr %0d got %h expected %h", t, a, reg_rdata, e);
        end
    endtask

    task automatic set_cnt(input logic [63:0] v);
        @(posedge clk); #2;
        cnt_ld_val = v; cnt_ld = 1'b1;
        @(posedge clk); #2;
        cnt_ld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_up;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        idle(3);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 32'h0000_000C, "R1 cfg lo");
        rd_chk(3'd1, 32'h0000_0004, "R1 cfg hi");
        rd_chk(3'd2, 32'hFFFF_FFFF, "R1 cmp lo");
        rd_chk(3'd3, 32'hFFFF_FFFF, "R1 cmp hi");
        rd_chk(3'd4, 32'h0, "R1 route lo");
        rd_chk(3'd5, 32'h0, "R1 route hi");

        // R2 write mask and read-only high half
        wr(3'd0, 32'hFFFF_FFF3);
        rd_chk(3'd0, 32'h0000_003F, "R2 cfg mask");
        wr(3'd0, 32'h0);
        rd_chk(3'd0, 32'h0000_000C, "R2 caps kept");
        wr(3'd1, 32'h0);
        rd_chk(3'd1, 32'h0000_0004, "R2 cfg hi ignored");

        // R10 unused address
        wr(3'd6, 32'hDEAD_BEEF);
        rd_chk(3'd6, 32'h0, "R10 unused read");
        rd_chk(3'd0, 32'h0000_000C, "R10 cfg untouched");

        // R8 halves
        wr(3'd4, 32'hA5A5_0001);
        wr(3'd5, 32'h1234_5678);
        wr(3'd4, 32'h0000_0002);
        rd_chk(3'd5, 32'h1234_5678, "R8 route hi kept");
        rd_chk(3'd4, 32'h0000_0002, "R8 route lo");

        // R9 64-bit compare: low half match alone must not fire
        wr(3'd3, 32'h0000_0001);
        wr(3'd2, 32'h0000_0010);
        rd_chk(3'd3, 32'h0000_0001, "R8 cmp hi kept");
        set_cnt(64'h0);
        cnt_run = 1'b1;
        wr(3'd0, 32'h1);
        idle(48);
        expect_fire(64'h1_0000_0010, "R9 wide match");
        set_cnt(64'h1_0000_0000);
        idle(40);
        wr(3'd0, 32'h0);
        cnt_run = 1'b0;

        // R4 / R5 periodic with period load
        set_cnt(64'h100);
        wr(3'd0, 32'h22);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h22);
        wr(3'd2, 32'h110);
        wr(3'd2, 32'h20);
        rd_chk(3'd2, 32'h0000_0110, "R4 cmp kept without load flag");
        rd_chk(3'd0, 32'h0000_000E, "R4 load flag cleared");
        expect_fire(64'h110, "R5 periodic 1");
        expect_fire(64'h130, "R5 periodic 2");
        expect_fire(64'h150, "R5 periodic 3");
        cnt_run = 1'b1;
        wr(3'd0, 32'h3);
        idle(80);
        wr(3'd0, 32'h2);
        cnt_run = 1'b0;
        rd_chk(3'd2, 32'h0000_0170, "R5 cmp advanced");

        // R3 narrow truncation
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0000_0005);
        rd_chk(3'd3, 32'h0000_0005, "R3 cmp hi before narrow");
        wr(3'd0, 32'h10);
        rd_chk(3'd3, 32'h0, "R3 cmp hi truncated");
        wr(3'd3, 32'h0000_0007);
        rd_chk(3'd3, 32'h0, "R3 cmp hi ignored when narrow");

        // R9 narrow compare on low half only
        set_cnt(64'h7_0000_0200);
        wr(3'd2, 32'h208);
        expect_fire(64'h7_0000_0208, "R9 narrow match");
        cnt_run = 1'b1;
        wr(3'd0, 32'h11);
        idle(24);
        wr(3'd0, 32'h10);
        cnt_run = 1'b0;

        // R5 narrow periodic addition wraps at 32 bits
        set_cnt(64'h0_FFFF_FFF0);
        wr(3'd0, 32'h32);
        wr(3'd2, 32'hFFFF_FFF8);
        wr(3'd2, 32'h10);
        expect_fire(64'h0_FFFF_FFF8, "R5 narrow 1");
        expect_fire(64'h1_0000_0008, "R5 narrow wrap");
        expect_fire(64'h1_0000_0018, "R5 narrow 3");
        cnt_run = 1'b1;
        wr(3'd0, 32'h13);
        idle(36);
        wr(3'd0, 32'h12);
        cnt_run = 1'b0;
        rd_chk(3'd2, 32'h0000_0028, "R5 narrow cmp");
        rd_chk(3'd3, 32'h0, "R5 narrow cmp hi");

        // R6 one-shot narrow wrap event
        wr(3'd0, 32'h10);
        wr(3'd2, 32'h20);
        set_cnt(64'h2_FFFF_FFF0);
        wr(3'd0, 32'h11);
        expect_fire(64'h3_0000_0000, "R6 wrap event");
        expect_fire(64'h3_0000_0020, "R6 match after wrap");
        cnt_run = 1'b1;
        idle(60);
        wr(3'd0, 32'h10);
        cnt_run = 1'b0;

        // R6 re-arm with target ahead: no extra event
        wr(3'd2, 32'h40);
        set_cnt(64'h3_0000_0030);
        wr(3'd0, 32'h11);
        expect_fire(64'h3_0000_0040, "R6 rearm single");
        cnt_run = 1'b1;
        idle(30);
        wr(3'd0, 32'h0);
        cnt_run = 1'b0;

        // R9 held counter gives one strobe
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h700);
        set_cnt(64'h700);
        expect_fire(64'h700, "R9 held single");
        wr(3'd0, 32'h1);
        idle(10);
        wr(3'd0, 32'h0);

        // R7 disarm before target: no fire
        set_cnt(64'h5C0);
        wr(3'd2, 32'h600);
        cnt_run = 1'b1;
        wr(3'd0, 32'h1);
        idle(4);
        wr(3'd0, 32'h0);
        idle(120);
        cnt_run = 1'b0;
        rd_chk(3'd0, 32'h0000_000C, "R7 disarmed cfg");

        idle(5);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing fires got %0d left expected 0", exp_q.size());
        end
        finish_up();
    end
endmodule